// File: doc/BRIEF.md
# Quad-Data-Rate Burst-of-Two SRAM Core

This block is a synthesizable model of a synchronous static memory that has one port for reads and a separate port for writes. A read and a write can both be issued at the same rising edge of the input clock. Every address holds a pair of words. A write delivers its two words on the rising edges of the two complementary input clocks. A read returns its two words on the two edges of the output clock pair. Each byte lane of each beat has its own active-low write select. Depth and widths are parameters, and the defaults keep the array small for simulation.

The read and write selects are sampled only when the true input clock rises. The read address shares the address bus with the write address, and it is taken at that same edge. The write address is taken half a cycle later, when the complementary input clock rises, together with the second write beat. Read data comes back one and a half cycles after the read command. A valid flag covers both beats of the pair. If both output clocks are held high while reset is asserted, the block takes its output timing from the input clocks instead. The timing seen at the outputs is the same in that mode.

Top module: `qdr_b2_sram`

## Requirements
- R1: A read to one address and a write to another address, issued at the same rising edge of `k_clk`, both take effect.
- R2: `rd_sel_n` and `wr_sel_n` are active low and are sampled only at the rising edge of `k_clk`. For a read sampled at time t, `q_valid` is high from t+1.5 cycles to t+2.5 cycles. Outside reads, `q_valid` stays low.
- R3: While `wr_sel_n` is high at a `k_clk` rising edge, the values on `d` and `bw_n` in that cycle leave the array unchanged.
- R4: A write stores the `d` value taken at the `k_clk` rising edge as word 0. It stores the `d` value taken at the next `kb_clk` rising edge as word 1. Both words go to the `addr` value taken at that `kb_clk` edge.
- R5: `bw_n` bit 0 low enables writing word bits 8:0, and `bw_n` bit 1 low enables bits 17:9. A lane whose bit is high keeps its old contents.
- R6: The `bw_n` value taken at the `k_clk` edge masks word 0. The value taken at the following `kb_clk` edge masks word 1, independently of the first.
- R7: A read returns word 0 while the negative output clock phase is active (t+1.5 to t+2 cycles), then word 1 during the next positive phase (t+2 to t+2.5 cycles).
- R8: A read and a write to the same address issued at the same `k_clk` edge return the contents held before that write. A later read returns the new contents.
- R9: If `c_clk` and `cb_clk` are both high while `rst_n` is low, output timing follows `k_clk`/`kb_clk`. In that mode, latency and beat order are the same as in R2 and R7.
- R10: After reset, `q_valid` is low until a read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| k_clk | input | 1 | Input clock, true phase |
| kb_clk | input | 1 | Input clock, complementary phase |
| c_clk | input | 1 | Output clock, true phase |
| cb_clk | input | 1 | Output clock, complementary phase |
| rst_n | input | 1 | Active-low reset, synchronous for the strap capture |
| rd_sel_n | input | 1 | Read select, active low |
| wr_sel_n | input | 1 | Write select, active low |
| addr | input | ADDR_W | Shared read and write address |
| d | input | WORD_W | Write data, both input clock edges |
| bw_n | input | WORD_W/LANE_W | Per-lane write enables, active low |
| q | output | WORD_W | Read data, both output clock phases |
| q_valid | output | 1 | High while q carries a read beat |

## Verification
The assertions check on every cycle that:
- each sampled read command brings the word-0 valid bit up two `k_clk` edges later;
- that valid bit never rises without such a command;
- the word-1 valid bit only follows a word-0 valid bit;
- a deselected write never leaves a write pending.

The data contents can only be shown by the bench's scenarios:
- byte-lane merging per beat;
- old-data return on a same-address collision;
- the effect of a deselected write;
- the exact sampling instants of both beats with and without the output-clock strap.

// File: rtl/qdr_b2_pkg.sv
`timescale 1ns/1ps
package qdr_b2_pkg;
   localparam int unsigned DEF_WORD_W = 18;
   localparam int unsigned DEF_LANE_W = 9;
   localparam int unsigned DEF_ADDR_W = 4;

   function automatic int unsigned lane_count(input int unsigned word_w, input int unsigned lane_w);
      return word_w / lane_w;
   endfunction
endpackage

// File: rtl/qdr_b2_wcap.sv
`timescale 1ns/1ps
// First-beat write capture at the true input clock edge.
module qdr_b2_wcap #(
   parameter int unsigned WORD_W = qdr_b2_pkg::DEF_WORD_W,
   parameter int unsigned LANE_W = qdr_b2_pkg::DEF_LANE_W
) (
   input  logic                       k_clk,
   input  logic                       rst_n,
   input  logic                       wr_sel_n,
   input  logic [WORD_W-1:0]          d,
   input  logic [WORD_W/LANE_W-1:0]   bw_n,
   output logic                       wr_pend,
   output logic [WORD_W-1:0]          beat0,
   output logic [WORD_W/LANE_W-1:0]   mask0_n
);
   always_ff @(posedge k_clk or negedge rst_n) begin
      if (!rst_n) wr_pend <= 1'b0;
      else        wr_pend <= !wr_sel_n;
   end

   // data and mask are only loaded on a selected write (R3)
   always_ff @(posedge k_clk) begin
      if (!wr_sel_n) begin
         beat0   <= d;
         mask0_n <= bw_n;
      end
   end
endmodule

// File: rtl/qdr_b2_store.sv
`timescale 1ns/1ps
// Storage: each entry holds a two-word burst, written at the complementary input edge.
module qdr_b2_store #(
   parameter int unsigned WORD_W = qdr_b2_pkg::DEF_WORD_W,
   parameter int unsigned LANE_W = qdr_b2_pkg::DEF_LANE_W,
   parameter int unsigned ADDR_W = qdr_b2_pkg::DEF_ADDR_W
) (
   input  logic                       kb_clk,
   input  logic                       we,
   input  logic [ADDR_W-1:0]          waddr,
   input  logic [WORD_W-1:0]          wd0,
   input  logic [WORD_W-1:0]          wd1,
   input  logic [WORD_W/LANE_W-1:0]   wm0_n,
   input  logic [WORD_W/LANE_W-1:0]   wm1_n,
   input  logic [ADDR_W-1:0]          raddr,
   output logic [WORD_W-1:0]          rd0,
   output logic [WORD_W-1:0]          rd1
);
   localparam int unsigned DEPTH = 1 << ADDR_W;
   localparam int unsigned NLANE = qdr_b2_pkg::lane_count(WORD_W, LANE_W);

   logic [WORD_W-1:0] mem0 [DEPTH];
   logic [WORD_W-1:0] mem1 [DEPTH];
   logic [WORD_W-1:0] cur0, cur1, nxt0, nxt1;

   assign cur0 = mem0[waddr];
   assign cur1 = mem1[waddr];

   // per-lane merge, each beat with its own mask (R5, R6)
   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      assign nxt0[g*LANE_W +: LANE_W] = wm0_n[g] ? cur0[g*LANE_W +: LANE_W] : wd0[g*LANE_W +: LANE_W];
      assign nxt1[g*LANE_W +: LANE_W] = wm1_n[g] ? cur1[g*LANE_W +: LANE_W] : wd1[g*LANE_W +: LANE_W];
   end

   always_ff @(posedge kb_clk) begin
      if (we) begin
         mem0[waddr] <= nxt0;
         mem1[waddr] <= nxt1;
      end
   end

   assign rd0 = mem0[raddr];
   assign rd1 = mem1[raddr];
endmodule

// File: rtl/qdr_b2_rpipe.sv
`timescale 1ns/1ps
// Read pipeline: array sampled at the true input edge, launched on both output phases.
module qdr_b2_rpipe #(
   parameter int unsigned WORD_W   = qdr_b2_pkg::DEF_WORD_W,
   parameter bit          STRAP_EN = 1'b1
) (
   input  logic              k_clk,
   input  logic              kb_clk,
   input  logic              c_clk,
   input  logic              cb_clk,
   input  logic              rst_n,
   input  logic              rd_sel_n,
   input  logic [WORD_W-1:0] rd0,
   input  logic [WORD_W-1:0] rd1,
   output logic [WORD_W-1:0] q_n,
   output logic [WORD_W-1:0] q_p,
   output logic              vld_n,
   output logic              vld_p,
   output logic              oclk_p
);
   logic              strap_q;
   logic              oclk_n;
   logic              v1, v2, v3, v4;
   logic [WORD_W-1:0] a1w0, a1w1, a2w0, a2w1, a3w0, a3w1, a4w1;

   if (STRAP_EN) begin : g_strap
      // strap is loaded only while reset is held (R9)
      always_ff @(posedge k_clk) begin
         if (!rst_n) strap_q <= c_clk & cb_clk;
      end
   end else begin : g_nostrap
      assign strap_q = 1'b0;
   end

   assign oclk_p = strap_q ? k_clk  : c_clk;
   assign oclk_n = strap_q ? kb_clk : cb_clk;

   // stage 1: array read at the command edge, before the same-cycle write (R8)
   always_ff @(posedge k_clk or negedge rst_n) begin
      if (!rst_n) v1 <= 1'b0;
      else        v1 <= !rd_sel_n;
   end
   always_ff @(posedge k_clk) begin
      if (!rd_sel_n) begin
         a1w0 <= rd0;
         a1w1 <= rd1;
      end
   end

   // stage 2 at +0.5 cycle
   always_ff @(posedge kb_clk or negedge rst_n) begin
      if (!rst_n) v2 <= 1'b0;
      else        v2 <= v1;
   end
   always_ff @(posedge kb_clk) begin
      a2w0 <= a1w0;
      a2w1 <= a1w1;
   end

   // stage 3 at +1 cycle, stable across the word-0 launch edge
   always_ff @(posedge k_clk or negedge rst_n) begin
      if (!rst_n) v3 <= 1'b0;
      else        v3 <= v2;
   end
   always_ff @(posedge k_clk) begin
      a3w0 <= a2w0;
      a3w1 <= a2w1;
   end

   // stage 4 at +1.5 cycle, stable across the word-1 launch edge
   always_ff @(posedge kb_clk or negedge rst_n) begin
      if (!rst_n) v4 <= 1'b0;
      else        v4 <= v3;
   end
   always_ff @(posedge kb_clk) begin
      a4w1 <= a3w1;
   end

   // word 0 on the negative output phase at +1.5 cycle (R2, R7)
   always_ff @(posedge oclk_n or negedge rst_n) begin
      if (!rst_n) vld_n <= 1'b0;
      else        vld_n <= v3;
   end
   always_ff @(posedge oclk_n) begin
      q_n <= a3w0;
   end

   // word 1 on the positive output phase at +2 cycles (R7)
   always_ff @(posedge oclk_p or negedge rst_n) begin
      if (!rst_n) vld_p <= 1'b0;
      else        vld_p <= v4;
   end
   always_ff @(posedge oclk_p) begin
      q_p <= a4w1;
   end
endmodule

// File: rtl/qdr_b2_sram.sv
`timescale 1ns/1ps
module qdr_b2_sram #(
   parameter int unsigned WORD_W   = qdr_b2_pkg::DEF_WORD_W,
   parameter int unsigned LANE_W   = qdr_b2_pkg::DEF_LANE_W,
   parameter int unsigned ADDR_W   = qdr_b2_pkg::DEF_ADDR_W,
   parameter bit          STRAP_EN = 1'b1
) (
   input  logic                       k_clk,
   input  logic                       kb_clk,
   input  logic                       c_clk,
   input  logic                       cb_clk,
   input  logic                       rst_n,
   input  logic                       rd_sel_n,
   input  logic                       wr_sel_n,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [WORD_W-1:0]          d,
   input  logic [WORD_W/LANE_W-1:0]   bw_n,
   output logic [WORD_W-1:0]          q,
   output logic                       q_valid
);
   localparam int unsigned NLANE = qdr_b2_pkg::lane_count(WORD_W, LANE_W);

   if (LANE_W == 0 || WORD_W % LANE_W != 0) begin : g_bad_lane
      $error("qdr_b2_sram: WORD_W must be a multiple of LANE_W");
   end
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
      $error("qdr_b2_sram: ADDR_W out of range");
   end

   logic                wr_pend_w;
   logic [WORD_W-1:0]   beat0_w;
   logic [NLANE-1:0]    mask0_w;
   logic [WORD_W-1:0]   rd0_w, rd1_w;
   logic [WORD_W-1:0]   q_n_w, q_p_w;
   logic                vld_n_w, vld_p_w, oclk_p_w;

   qdr_b2_wcap #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_wcap (
      .k_clk   (k_clk),
      .rst_n   (rst_n),
      .wr_sel_n(wr_sel_n),
      .d       (d),
      .bw_n    (bw_n),
      .wr_pend (wr_pend_w),
      .beat0   (beat0_w),
      .mask0_n (mask0_w)
   );

   // write address and second beat come straight from the pins at kb_clk (R4)
   qdr_b2_store #(.WORD_W(WORD_W), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_store (
      .kb_clk(kb_clk),
      .we    (wr_pend_w),
      .waddr (addr),
      .wd0   (beat0_w),
      .wd1   (d),
      .wm0_n (mask0_w),
      .wm1_n (bw_n),
      .raddr (addr),
      .rd0   (rd0_w),
      .rd1   (rd1_w)
   );

   qdr_b2_rpipe #(.WORD_W(WORD_W), .STRAP_EN(STRAP_EN)) u_rpipe (
      .k_clk   (k_clk),
      .kb_clk  (kb_clk),
      .c_clk   (c_clk),
      .cb_clk  (cb_clk),
      .rst_n   (rst_n),
      .rd_sel_n(rd_sel_n),
      .rd0     (rd0_w),
      .rd1     (rd1_w),
      .q_n     (q_n_w),
      .q_p     (q_p_w),
      .vld_n   (vld_n_w),
      .vld_p   (vld_p_w),
      .oclk_p  (oclk_p_w)
   );

   // double-rate output select by output clock phase
   assign q       = oclk_p_w ? q_p_w   : q_n_w;
   assign q_valid = oclk_p_w ? vld_p_w : vld_n_w;
endmodule

// File: rtl/qdr_b2_sram_chk.sv
`timescale 1ns/1ps
module qdr_b2_sram_chk (
   input logic k_clk,
   input logic rst_n,
   input logic rd_sel_n,
   input logic wr_sel_n,
   input logic vld_n,
   input logic vld_p,
   input logic wr_pend
);
   logic [1:0] since_rst;

   always_ff @(posedge k_clk or negedge rst_n) begin
      if (!rst_n)                 since_rst <= 2'd0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R2: a sampled read raises the word-0 valid two true-clock edges later
   a_r2_read_valid: assert property (@(posedge k_clk) disable iff (!rst_n)
      !rd_sel_n |=> ##1 vld_n);

   // R2: word-0 valid only ever follows a read command
   a_r2_valid_has_cmd: assert property (@(posedge k_clk) disable iff (!rst_n)
      (since_rst >= 2'd2 && vld_n) |-> $past(!rd_sel_n, 2));

   // R7: word 1 is only launched after word 0 of the same burst
   a_r7_q1_after_q0: assert property (@(posedge k_clk) disable iff (!rst_n)
      (since_rst >= 2'd1 && vld_p) |-> $past(vld_n));

   // R3: a deselected write leaves nothing pending for the array
   a_r3_no_write_when_idle: assert property (@(posedge k_clk) disable iff (!rst_n)
      wr_sel_n |=> !wr_pend);
endmodule

bind qdr_b2_sram qdr_b2_sram_chk u_chk (
   .k_clk   (k_clk),
   .rst_n   (rst_n),
   .rd_sel_n(rd_sel_n),
   .wr_sel_n(wr_sel_n),
   .vld_n   (vld_n_w),
   .vld_p   (vld_p_w),
   .wr_pend (wr_pend_w)
);

// File: tb/qdr_b2_sram_test.sv
`timescale 1ns/1ps
module qdr_b2_sram_test;
   localparam int unsigned W  = 18;
   localparam int unsigned L  = 9;
   localparam int unsigned AW = 4;
   localparam int unsigned NL = W / L;

   typedef struct {
      logic [W-1:0] w0;
      logic [W-1:0] w1;
      realtime      t0;
      string        tag;
   } exp_t;

   logic          k_clk = 1'b0;
   logic          kb_clk;
   logic          c_clk, cb_clk;
   logic          hold_c = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_sel_n = 1'b1;
   logic          wr_sel_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [W-1:0]  d = '0;
   logic [NL-1:0] bw_n = '1;
   logic [W-1:0]  q;
   logic          q_valid;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   exp_t sbq[$];
   exp_t mon_e;
   logic [W-1:0] mdl0 [1<<AW];
   logic [W-1:0] mdl1 [1<<AW];

   always #5 k_clk = ~k_clk;
   assign kb_clk = ~k_clk;
   assign c_clk  = hold_c ? 1'b1 : k_clk;
   assign cb_clk = hold_c ? 1'b1 : kb_clk;

   qdr_b2_sram #(.WORD_W(W), .LANE_W(L), .ADDR_W(AW)) uut (
      .k_clk(k_clk), .kb_clk(kb_clk), .c_clk(c_clk), .cb_clk(cb_clk),
      .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
      .addr(addr), .d(d), .bw_n(bw_n), .q(q), .q_valid(q_valid)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [W-1:0] merge(input logic [W-1:0] old, input logic [W-1:0] nw,
                                          input logic [NL-1:0] m_n);
      logic [W-1:0] r = old;
      for (int i = 0; i < NL; i++)
         if (!m_n[i]) r[i*L +: L] = nw[i*L +: L];
      return r;
   endfunction

   // driver: one command cycle; expectation pushed at the sampling edge
   task automatic op(input bit rd, input logic [AW-1:0] ra, input bit wr, input logic [AW-1:0] wa,
                     input logic [W-1:0] d0, input logic [W-1:0] d1,
                     input logic [NL-1:0] m0, input logic [NL-1:0] m1, input string tag);
      exp_t e;
      @(posedge kb_clk); #1;
      rd_sel_n = !rd; wr_sel_n = !wr; addr = ra; d = d0; bw_n = m0;
      if (rd) begin
         e.w0 = mdl0[ra]; e.w1 = mdl1[ra]; e.tag = tag;
      end
      @(posedge k_clk);
      if (rd) begin
         e.t0 = $realtime;
         sbq.push_back(e);
      end
      #1;
      rd_sel_n = 1'b1; wr_sel_n = 1'b1; addr = wa; d = d1; bw_n = m1;
      if (wr) begin
         mdl0[wa] = merge(mdl0[wa], d0, m0);
         mdl1[wa] = merge(mdl1[wa], d1, m1);
      end
   endtask

   task automatic wr_op(input logic [AW-1:0] a, input logic [W-1:0] d0, input logic [W-1:0] d1,
                        input logic [NL-1:0] m0, input logic [NL-1:0] m1);
      op(1'b0, a, 1'b1, a, d0, d1, m0, m1, "");
   endtask

   task automatic rd_op(input logic [AW-1:0] a, input string tag);
      op(1'b1, a, 1'b0, a, '0, '0, '1, '1, tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) op(1'b0, '0, 1'b0, '0, '0, '0, '1, '1, "");
   endtask

   task automatic do_reset(input bit strap);
      @(posedge kb_clk); #1;
      rst_n = 1'b0; hold_c = strap;
      rd_sel_n = 1'b1; wr_sel_n = 1'b1;
      repeat (4) @(posedge k_clk);
      #1 rst_n = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(posedge kb_clk); #2.5;
         check(q_valid == 1'b0, "R10", "valid low after reset (neg phase)", {17'b0, q_valid}, '0);
         #5;
         check(q_valid == 1'b0, "R10", "valid low after reset (pos phase)", {17'b0, q_valid}, '0);
      end
   endtask

   // monitor: pops one burst per valid word-0 phase
   initial begin
      forever begin
         @(posedge kb_clk); #2.5;
         if (q_valid === 1'b1) begin
            if (sbq.size() == 0) begin
               check(1'b0, "R2", "valid without a read", {17'b0, q_valid}, '0);
            end else begin
               mon_e = sbq.pop_front();
               check(($realtime - mon_e.t0) == 17.5, "R2", "word 0 latency", W'(int'($realtime - mon_e.t0)), W'(17));
               check(q == mon_e.w0, mon_e.tag, "word 0 (R7)", q, mon_e.w0);
               #5;
               check(q_valid == 1'b1, "R2", "valid held for word 1", {17'b0, q_valid}, W'(1));
               check(q == mon_e.w1, mon_e.tag, "word 1 (R7)", q, mon_e.w1);
            end
         end
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < (1 << AW); i++) begin
         mdl0[i] = '0; mdl1[i] = '0;
      end
      do_reset(1'b0);
      // R4: two-word burst
      wr_op(4'd3, 18'h0a5a5, 18'h15a5a, 2'b00, 2'b00);
      rd_op(4'd3, "R4");
      // R3: deselected write with data driven
      op(1'b0, 4'd3, 1'b0, 4'd3, 18'h3ffff, 18'h3ffff, 2'b00, 2'b00, "");
      rd_op(4'd3, "R3");
      // R5: only upper lane written on both beats
      wr_op(4'd5, 18'h11111, 18'h22222, 2'b00, 2'b00);
      wr_op(4'd5, 18'h3fe00, 18'h3fe00, 2'b01, 2'b01);
      rd_op(4'd5, "R5");
      // R6: different masks per beat
      wr_op(4'd6, 18'h12345, 18'h06789, 2'b00, 2'b00);
      wr_op(4'd6, 18'h3ffff, 18'h3ffff, 2'b10, 2'b01);
      rd_op(4'd6, "R6");
      // R8: same-address read/write collision
      wr_op(4'd7, 18'h0beef, 18'h0cafe, 2'b00, 2'b00);
      op(1'b1, 4'd7, 1'b1, 4'd7, 18'h01234, 18'h04321, 2'b00, 2'b00, "R8");
      rd_op(4'd7, "R8");
      // R1: concurrent read and write to different addresses
      wr_op(4'd8, 18'h2aaaa, 18'h15555, 2'b00, 2'b00);
      op(1'b1, 4'd8, 1'b1, 4'd9, 18'h00f0f, 18'h3f0f0, 2'b00, 2'b00, "R1");
      rd_op(4'd9, "R1");
      // R7: back-to-back reads
      rd_op(4'd3, "R7");
      rd_op(4'd5, "R7");
      rd_op(4'd6, "R7");
      rd_op(4'd9, "R7");
      idle(4);
      // R9: output clocks strapped high through reset
      do_reset(1'b1);
      wr_op(4'd10, 18'h1c3c3, 18'h03c3c, 2'b00, 2'b00);
      rd_op(4'd10, "R9");
      rd_op(4'd7, "R9");
      idle(4);
      check(sbq.size() == 0, "R2", "every read returned", W'(sbq.size()), '0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule